// File: doc/BRIEF.md
# Banked DRAM Burst Address Generator

This block turns one short command into a stream of 32-bit DRAM beat addresses. In burst mode the command carries a transaction count, a base row and a read/write type. The generator splits the count into whole rows, then whole banks of one partial row, then single column beats of one partial bank. It walks those three groups in that order and presents one address per beat on a valid/ready stream, with the read/write flag alongside.

In write-back mode the command carries a frame index instead of a count. The block then emits a fixed result pattern: 56 rows starting at row 56 × frame. Within each row it steps through every column position, and the bank is the fastest-moving field. Every beat in this mode is a write.

A one-cycle done pulse marks the end of each command. While a command is running, further start requests are dropped. The consumer can stall the stream for any length of time, and the presented beat stays unchanged until it is taken.

Top module: `dram_burst_addr_gen`

## Requirements
- R1: Each address is packed as bit 31 = 0, bits 30:28 = bank, bits 27:13 = row, bits 12:6 = column, bits 5:0 = 0. Columns are multiples of 8 (0, 8, …, 120), so bits 8:6 are also 0 and bits 12:9 carry the column beat index 0–15.
- R2: In burst mode the number of beats equals the count. The count splits into full rows = count / 128, leftover banks = (count / 16) mod 8 and leftover columns = count mod 16, emitted in that group order.
- R3: Full rows are walked with the row offset outermost, then banks 0–7, then column beats 0–15 innermost. The row field is base row + row offset, truncated to 15 bits.
- R4: Leftover banks use row base + full rows. They are banks 0 up to the leftover bank count minus one, each with all 16 column beats in ascending order.
- R5: Leftover columns use row base + full rows and the bank equal to the leftover bank count. They are column beat indices 0 up to the leftover column count minus one.
- R6: In burst mode every beat carries the read/write flag captured at start (1 = write, 0 = read).
- R7: In write-back mode (mode = 1) the block emits 7168 beats. Rows run from 56 × frame to 56 × frame + 55, with row outermost, then column beat 0–15, then bank 0–7 innermost. Every beat carries write = 1.
- R8: A burst start with count 0 emits no beats and raises done in the cycle after the start.
- R9: Done is high for exactly one cycle, in the cycle after the handshake of the last beat, and valid is low while done is high. Done is low after reset.
- R10: While valid is high and ready is low, the address and the read/write flag hold their values and valid stays high.
- R11: A start while a command is in progress is ignored. The running stream continues unchanged.
- R12: Valid is low after reset and rises in the cycle after a start with a non-empty command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a command (taken only when idle) |
| mode_i | input | 1 | 0 = counted burst, 1 = result write-back |
| count_i | input | CNT_W | Beat count for burst mode |
| base_row_i | input | 15 | Base row for burst mode |
| wr_i | input | 1 | Burst read/write type, 1 = write |
| frame_i | input | FRM_W | Frame index for write-back mode |
| out_valid_o | output | 1 | Beat available |
| out_ready_i | input | 1 | Consumer takes the beat |
| out_addr_o | output | 32 | Beat address |
| out_wr_o | output | 1 | Beat type, 1 = write |
| done_o | output | 1 | One-cycle end-of-command pulse |

## Verification
A start captured at a clock edge makes valid visible one cycle later, or done for a zero count. Each beat advances at the edge where valid and ready are both high. Done follows one cycle after the edge that takes the last beat.

The bench drives its inputs shortly after the rising edge and samples at the falling edge. At each falling edge it pops the expected beat whenever valid and ready are both high. It checks for done at the falling edge that follows the pop which empties the queue, and at the first falling edge after a start it looks for valid or done.

Stalls come from a pseudo-random ready pattern. Every stalled beat is compared at the next falling edge.

// File: rtl/agb_pkg.sv
package agb_pkg;
  localparam int BANK_W    = 3;
  localparam int ROW_W     = 15;
  localparam int CIDX_W    = 4;
  localparam int ADDR_W    = 32;
  localparam int LOW_ZEROS = 9;
  localparam int WB_ROWS   = 56;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ROWS  = 3'd1,
    PH_BANKS = 3'd2,
    PH_COLS  = 3'd3,
    PH_WB    = 3'd4
  } phase_e;
endpackage

// File: rtl/agb_split.sv
module agb_split #(
  parameter int CNT_W = 16,
  parameter int RO_W  = 9
) (
  input  logic [CNT_W-1:0]              count_i,
  output logic [RO_W-1:0]               rnum_o,
  output logic [agb_pkg::BANK_W-1:0]    bnum_o,
  output logic [agb_pkg::CIDX_W-1:0]    cnum_o
);
  localparam int GRP_SHIFT = agb_pkg::BANK_W + agb_pkg::CIDX_W;

  always_comb begin
    rnum_o = RO_W'(count_i >> GRP_SHIFT);
    bnum_o = count_i[GRP_SHIFT-1:agb_pkg::CIDX_W];
    cnum_o = count_i[agb_pkg::CIDX_W-1:0];
  end
endmodule

// File: rtl/agb_walk.sv
module agb_walk
  import agb_pkg::*;
#(
  parameter int RO_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [RO_W-1:0]     rnum_i,
  input  logic [BANK_W-1:0]   bnum_i,
  input  logic [CIDX_W-1:0]   cnum_i,
  input  logic                fire_i,
  output phase_e              phase_o,
  output logic [RO_W-1:0]     rowoff_o,
  output logic [BANK_W-1:0]   bank_o,
  output logic [CIDX_W-1:0]   cidx_o,
  output logic                done_o
);
  localparam logic [BANK_W-1:0] LAST_B  = '1;
  localparam logic [CIDX_W-1:0] LAST_C  = '1;
  localparam logic [RO_W-1:0]   WB_LAST = RO_W'(WB_ROWS - 1);

  phase_e              ph_q, ph_d;
  logic [RO_W-1:0]     row_q, row_d, rn_q, rn_d;
  logic [BANK_W-1:0]   bank_q, bank_d, bn_q, bn_d;
  logic [CIDX_W-1:0]   cidx_q, cidx_d, cn_q, cn_d;
  logic                done_q, done_d;

  always_comb begin
    ph_d   = ph_q;   row_d = row_q; bank_d = bank_q; cidx_d = cidx_q;
    rn_d   = rn_q;   bn_d  = bn_q;  cn_d   = cn_q;   done_d = 1'b0;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        row_d = '0; bank_d = '0; cidx_d = '0;
        rn_d  = rnum_i; bn_d = bnum_i; cn_d = cnum_i;
        if (mode_i)               ph_d = PH_WB;
        else if (rnum_i != '0)    ph_d = PH_ROWS;
        else if (bnum_i != '0)    ph_d = PH_BANKS;
        else if (cnum_i != '0)    ph_d = PH_COLS;
        else                      done_d = 1'b1;
      end
      PH_ROWS: if (fire_i) begin
        cidx_d = cidx_q + 1'b1;
        if (cidx_q == LAST_C) begin
          bank_d = bank_q + 1'b1;
          if (bank_q == LAST_B) begin
            row_d = row_q + 1'b1;
            if (row_q == rn_q - 1'b1) begin
              if (bn_q != '0)      ph_d = PH_BANKS;
              else if (cn_q != '0) ph_d = PH_COLS;
              else begin           ph_d = PH_IDLE; done_d = 1'b1; end
            end
          end
        end
      end
      PH_BANKS: if (fire_i) begin
        cidx_d = cidx_q + 1'b1;
        if (cidx_q == LAST_C) begin
          bank_d = bank_q + 1'b1;
          if (bank_q == bn_q - 1'b1) begin
            if (cn_q != '0) ph_d = PH_COLS;
            else begin      ph_d = PH_IDLE; done_d = 1'b1; end
          end
        end
      end
      PH_COLS: if (fire_i) begin
        cidx_d = cidx_q + 1'b1;
        if (cidx_q == cn_q - 1'b1) begin
          ph_d = PH_IDLE; done_d = 1'b1;
        end
      end
      PH_WB: if (fire_i) begin
        bank_d = bank_q + 1'b1;
        if (bank_q == LAST_B) begin
          cidx_d = cidx_q + 1'b1;
          if (cidx_q == LAST_C) begin
            row_d = row_q + 1'b1;
            if (row_q == WB_LAST) begin
              ph_d = PH_IDLE; done_d = 1'b1;
            end
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      row_q  <= '0; bank_q <= '0; cidx_q <= '0;
      rn_q   <= '0; bn_q   <= '0; cn_q   <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      row_q  <= row_d; bank_q <= bank_d; cidx_q <= cidx_d;
      rn_q   <= rn_d;  bn_q   <= bn_d;   cn_q   <= cn_d;
      done_q <= done_d;
    end
  end

  assign phase_o  = ph_q;
  assign rowoff_o = row_q;
  assign bank_o   = bank_q;
  assign cidx_o   = cidx_q;
  assign done_o   = done_q;
endmodule

// File: rtl/agb_pack.sv
module agb_pack
  import agb_pkg::*;
#(
  parameter int RO_W  = 9,
  parameter int FRM_W = 8
) (
  input  phase_e              phase_i,
  input  logic [ROW_W-1:0]    base_row_i,
  input  logic [FRM_W-1:0]    frame_i,
  input  logic [RO_W-1:0]     rowoff_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [CIDX_W-1:0]   cidx_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [ROW_W-1:0] wb_base;
  logic [ROW_W-1:0] row_base;
  logic [ROW_W-1:0] row;

  always_comb begin
    wb_base  = ROW_W'(32'(frame_i) * 32'(WB_ROWS));
    row_base = (phase_i == PH_WB) ? wb_base : base_row_i;
    row      = ROW_W'(32'(row_base) + 32'(rowoff_i));
    addr_o   = {1'b0, bank_i, row, cidx_i, {LOW_ZEROS{1'b0}}};
  end
endmodule

// File: rtl/dram_burst_addr_gen.sv
module dram_burst_addr_gen
  import agb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FRM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic [ROW_W-1:0]     base_row_i,
  input  logic                 wr_i,
  input  logic [FRM_W-1:0]     frame_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [ADDR_W-1:0]    out_addr_o,
  output logic                 out_wr_o,
  output logic                 done_o
);
  localparam int RAW_RO = CNT_W - BANK_W - CIDX_W;
  localparam int RO_W   = (RAW_RO > 6) ? RAW_RO : 6;

  logic                rst_s1, rst_s2;
  phase_e              phase;
  logic [RO_W-1:0]     rnum, rowoff;
  logic [BANK_W-1:0]   bnum, bank;
  logic [CIDX_W-1:0]   cnum, cidx;
  logic                idle, take, fire;
  logic [ROW_W-1:0]    base_q;
  logic [FRM_W-1:0]    frame_q;
  logic                wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign idle = (phase == PH_IDLE);
  assign take = idle & start_i;
  assign fire = out_valid_o & out_ready_i;

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      base_q  <= '0;
      frame_q <= '0;
      wr_q    <= 1'b0;
    end else if (take) begin
      base_q  <= base_row_i;
      frame_q <= frame_i;
      wr_q    <= wr_i;
    end
  end

  agb_split #(.CNT_W(CNT_W), .RO_W(RO_W)) u_split (
    .count_i (count_i),
    .rnum_o  (rnum),
    .bnum_o  (bnum),
    .cnum_o  (cnum)
  );

  agb_walk #(.RO_W(RO_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_s2),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .rnum_i   (rnum),
    .bnum_i   (bnum),
    .cnum_i   (cnum),
    .fire_i   (fire),
    .phase_o  (phase),
    .rowoff_o (rowoff),
    .bank_o   (bank),
    .cidx_o   (cidx),
    .done_o   (done_o)
  );

  agb_pack #(.RO_W(RO_W), .FRM_W(FRM_W)) u_pack (
    .phase_i    (phase),
    .base_row_i (base_q),
    .frame_i    (frame_q),
    .rowoff_i   (rowoff),
    .bank_i     (bank),
    .cidx_i     (cidx),
    .addr_o     (out_addr_o)
  );

  assign out_valid_o = ~idle;
  assign out_wr_o    = (phase == PH_WB) | wr_q;
endmodule

// File: rtl/agb_checker.sv
module agb_checker #(
  parameter int CNT_W = 16,
  parameter int FRM_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mode_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [31:0]       out_addr_o,
  input logic              out_wr_o,
  input logic              done_o
);
  AST_ADDR_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_addr_o[31] == 1'b0 && out_addr_o[8:0] == 9'd0)); // R1

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_wr_o))); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !out_valid_o && !done_o && !mode_i && count_i == '0) |=> (done_o && !out_valid_o)); // R8

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && start_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_wr_o))); // R11
endmodule

bind dram_burst_addr_gen agb_checker #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .count_i     (count_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_addr_o  (out_addr_o),
  .out_wr_o    (out_wr_o),
  .done_o      (done_o)
);

// File: tb/sim_dram_burst_addr_gen.sv
module sim_dram_burst_addr_gen;
  localparam int CNT_W = 16;
  localparam int FRM_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i, mode_i, wr_i, out_ready_i;
  logic [CNT_W-1:0]  count_i;
  logic [14:0]       base_row_i;
  logic [FRM_W-1:0]  frame_i;
  logic              out_valid_o, out_wr_o, done_o;
  logic [31:0]       out_addr_o;

  int   total = 0;
  int   bad   = 0;
  logic [32:0] expq[$];
  string cur_tag = "R2";
  bit   done_pend = 0, seq_done = 0, zero_ok = 0;
  bit   hold_v = 0;
  logic [32:0] hold_a;
  bit   rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  dram_burst_addr_gen #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .count_i(count_i), .base_row_i(base_row_i), .wr_i(wr_i), .frame_i(frame_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_addr_o(out_addr_o),
    .out_wr_o(out_wr_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] mk(input bit w, input int bank, input int row, input int cidx);
    logic [31:0] a;
    a = {1'b0, 3'(bank), 15'(row), 4'(cidx), 9'd0};
    return {w, a};
  endfunction

  // ready pattern
  initial begin
    out_ready_i = 1'b1;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready_i = rdy_rand ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pend) begin
        chk(done_o == 1'b1, "R9 done after last beat", 64'(done_o), 64'd1);
        done_pend = 0;
        seq_done  = 1;
      end else if (done_o) begin
        if (zero_ok) begin
          zero_ok  = 0;
          seq_done = 1;
        end else chk(1'b0, "R9 unexpected done", 64'd1, 64'd0);
      end
      if (hold_v) chk(out_valid_o && {out_wr_o, out_addr_o} == hold_a, "R10 stall hold",
                      64'({out_wr_o, out_addr_o}), 64'(hold_a));
      hold_v = out_valid_o && !out_ready_i;
      hold_a = {out_wr_o, out_addr_o};
      if (out_valid_o && out_ready_i) begin
        chk(out_addr_o[31] == 1'b0 && out_addr_o[8:0] == 9'd0, "R1 zero fields", 64'(out_addr_o), 64'd0);
        if (expq.size() == 0) chk(1'b0, "R2 extra beat", 64'(out_addr_o), 64'd0);
        else begin
          logic [32:0] e;
          e = expq.pop_front();
          chk({out_wr_o, out_addr_o} == e, cur_tag, 64'({out_wr_o, out_addr_o}), 64'(e));
          if (expq.size() == 0) done_pend = 1;
        end
      end
    end
  end

  task automatic run(input bit md, input int cnt, input int base, input bit w,
                     input int frm, input bit poke, input string tag);
    seq_done = 0;
    cur_tag  = tag;
    if (md) begin
      for (int r = 0; r < 56; r++)
        for (int c = 0; c < 16; c++)
          for (int b = 0; b < 8; b++)
            expq.push_back(mk(1'b1, b, 56 * frm + r, c));
    end else begin
      int rn, bn, cn;
      rn = cnt / 128; bn = (cnt / 16) % 8; cn = cnt % 16;
      for (int r = 0; r < rn; r++)
        for (int b = 0; b < 8; b++)
          for (int c = 0; c < 16; c++)
            expq.push_back(mk(w, b, base + r, c));
      for (int b = 0; b < bn; b++)
        for (int c = 0; c < 16; c++)
          expq.push_back(mk(w, b, base + rn, c));
      for (int c = 0; c < cn; c++)
        expq.push_back(mk(w, bn, base + rn, c));
      if (cnt == 0) zero_ok = 1;
    end
    @(posedge clk); #2;
    start_i = 1'b1; mode_i = md; count_i = CNT_W'(cnt);
    base_row_i = 15'(base); wr_i = w; frame_i = FRM_W'(frm);
    @(posedge clk); #2;
    start_i = 1'b0;
    @(negedge clk);
    if (!md && cnt == 0)
      chk(done_o && !out_valid_o, "R8 zero count done", 64'({done_o, out_valid_o}), 64'd2);
    else
      chk(out_valid_o, "R12 valid after start", 64'(out_valid_o), 64'd1);
    if (poke) begin
      repeat (20) @(posedge clk);
      #2;
      start_i = 1'b1; mode_i = ~md; count_i = CNT_W'(3); frame_i = FRM_W'(9); wr_i = ~w;
      @(posedge clk); #2;
      start_i = 1'b0;
    end
    wait (seq_done);
    @(negedge clk);
    chk(expq.size() == 0 && !out_valid_o, "R2 command complete", 64'(expq.size()), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; wr_i = 1'b0;
    count_i = '0; base_row_i = '0; frame_i = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid_o, "R12 reset valid low", 64'(out_valid_o), 64'd0);
    chk(!done_o, "R9 reset done low", 64'(done_o), 64'd0);

    run(1'b0, 0,   10,  1'b0, 0, 1'b0, "R8");
    run(1'b0, 5,   20,  1'b0, 0, 1'b0, "R5 leftover columns");
    run(1'b0, 48,  30,  1'b1, 0, 1'b0, "R4 leftover banks");
    run(1'b0, 256, 40,  1'b0, 0, 1'b0, "R3 full rows");
    rdy_rand = 1;
    run(1'b0, 167, 100, 1'b1, 0, 1'b0, "R2 mixed split R6 write flag");
    run(1'b0, 300, 32766, 1'b0, 0, 1'b1, "R11 start ignored R3 row wrap");
    run(1'b0, 23,  500, 1'b0, 0, 1'b0, "R6 read flag");
    run(1'b1, 0,   0,   1'b0, 3, 1'b0, "R7 write-back frame 3");
    rdy_rand = 0;
    run(1'b1, 0,   0,   1'b0, 255, 1'b1, "R7 write-back frame 255 R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule